// File: doc/BRIEF.md
# PTP Event Frame Classifier

This block sits on the receive side of a single Ethernet port. It watches the incoming byte stream and decides, frame by frame, whether the frame is a precision-time-protocol event message. It also reports which kind of event message it is, Sync or Delay_Req.

Qualification is deliberately loose. The block looks only at the destination MAC address and at the integrity flag reported for the frame check sequence. It checks no EtherType, IP header or UDP header field.

There are five candidate destination addresses:

- four fixed multicast addresses;
- one address that the host programs.

Each address is switched on or off for this port by its own enable bit. A frame whose address matches then has its message-type byte examined. That byte sits 32 bytes into the UDP payload. The payload starts four bytes later when the frame carries a VLAN tag.

The result is held until the frame's last byte. It is then reported as a single-cycle pulse, together with the message kind and the index of the address that matched.

Top module: `ptp_evt_classifier`

## Requirements
- R1: A result pulse is produced only when `rx_fcs_ok` is high on the beat that carries `rx_eof`. With the flag low, the frame yields no pulse, whatever its contents.
- R2: The fixed addresses and their indices are:
  - index 0: 01:00:5e:00:01:81
  - index 1: 01:00:5e:00:01:82
  - index 2: 01:00:5e:00:01:83
  - index 3: 01:00:5e:00:01:84

  Frame bytes 0 to 5 form the destination address, with byte 0 as the most significant.
- R3: The host address is index 4. `cfg_user_hi` supplies frame bytes 0 to 1 and `cfg_user_lo` supplies bytes 2 to 5, most significant byte first.
- R4: Bit `PORT_SEL*5 + i` of `cfg_addr_en` enables address index i on this port. An address whose bit is clear never matches, even when another port's bit for it is set.
- R5: When several enabled addresses equal the destination address, the lowest index is reported.
- R6: In an untagged frame, the message-type byte is frame byte 74: payload start 42 plus offset 32.
- R7: A frame whose bytes 12 and 13 are 0x81 and 0x00 is treated as tagged. In a tagged frame, the message-type byte is frame byte 78, and byte 74 is ignored.
- R8: The message-type byte decides the result:
  - 0x00: reports Sync, with `ptp_is_delay_req` = 0;
  - 0x01: reports Delay_Req, with `ptp_is_delay_req` = 1;
  - any other value: no pulse.
- R9: A frame whose `rx_eof` beat falls at or before the message-type byte position yields no pulse.
- R10: `ptp_hit` is high for exactly one cycle, in the cycle after the `rx_eof` beat. While `ptp_hit` is low, `ptp_is_delay_req` and `ptp_addr_idx` are zero. All three outputs are zero after reset.
- R11: No field other than the destination address and the message-type byte affects the result. For example, an arbitrary EtherType still yields a pulse.
- R12: A beat with `rx_sof` high restarts byte counting at 0, discarding any unfinished frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A byte is present on `rx_data` this cycle |
| rx_sof | input | 1 | The current byte is frame byte 0 |
| rx_eof | input | 1 | The current byte is the last byte of the frame |
| rx_data | input | 8 | Received byte |
| rx_fcs_ok | input | 1 | Frame check sequence valid; sampled on the `rx_eof` beat |
| cfg_user_hi | input | 16 | Host address, upper two bytes |
| cfg_user_lo | input | 32 | Host address, lower four bytes |
| cfg_addr_en | input | 5*NUM_PORTS | Per-port, per-address enable bits |
| ptp_hit | output | 1 | One-cycle pulse marking a classified event frame |
| ptp_is_delay_req | output | 1 | 1 for Delay_Req, 0 for Sync |
| ptp_addr_idx | output | 3 | Index of the matching address |

## Verification
The bench builds the block with `NUM_PORTS` = 3 and `PORT_SEL` = 1. Its own port's enable bits therefore sit in the middle of the enable vector. Disabling an address on this port while leaving it enabled on ports 0 and 2 shows whether the slice is taken from the right place. The default byte offsets, 42 for the payload and 4 for the tag, are kept. This puts frames ending exactly on byte 74 or 78 within reach, which probes the early-end rule on both sides.

// File: rtl/ptp_cls_pkg.sv
package ptp_cls_pkg;
  localparam int unsigned NUM_ADDR = 5;
  localparam int unsigned NUM_FIXED = 4;
  localparam int unsigned IDX_W = 3;
  localparam logic [47:0] PTP_DA_BASE = 48'h01_00_5e_00_01_81;
  localparam logic [7:0] MSG_SYNC = 8'h00;
  localparam logic [7:0] MSG_DELAY = 8'h01;

  function automatic logic [47:0] fixed_da(input int unsigned n);
    return PTP_DA_BASE + 48'(n);
  endfunction
endpackage

// File: rtl/ptp_da_match.sv
module ptp_da_match
  import ptp_cls_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 beat,
  input  logic [CNT_W-1:0]     byte_idx,
  input  logic [7:0]           data,
  input  logic [47:0]          user_da,
  input  logic [NUM_ADDR-1:0]  en,
  output logic [NUM_ADDR-1:0]  hit_vec
);
  logic [47:0] da_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      da_q <= '0;
    end else if (beat) begin
      for (int k = 0; k < 6; k++) begin
        if (byte_idx == CNT_W'(k)) da_q[8*(5-k) +: 8] <= data;
      end
    end
  end

  for (genvar a = 0; a < NUM_ADDR; a++) begin : g_cmp
    if (a < NUM_FIXED) begin : g_fixed
      assign hit_vec[a] = en[a] && (da_q == fixed_da(a));
    end else begin : g_user
      assign hit_vec[a] = en[a] && (da_q == user_da);
    end
  end
endmodule

// File: rtl/ptp_type_pick.sv
module ptp_type_pick #(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned UNTAG_POS = 74,
  parameter int unsigned TAG_POS   = 78
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat,
  input  logic [CNT_W-1:0] byte_idx,
  input  logic [7:0]       data,
  output logic             type_valid,
  output logic [7:0]       type_byte
);
  logic             lead81_q;
  logic             tagged_q;
  logic             seen_q;
  logic [CNT_W-1:0] pos;

  assign pos = tagged_q ? CNT_W'(TAG_POS) : CNT_W'(UNTAG_POS);

  always_ff @(posedge clk) begin
    if (rst) begin
      lead81_q  <= 1'b0;
      tagged_q  <= 1'b0;
      seen_q    <= 1'b0;
      type_byte <= '0;
    end else if (beat) begin
      if (byte_idx == '0) begin
        tagged_q <= 1'b0;
        seen_q   <= 1'b0;
      end
      if (byte_idx == CNT_W'(12)) lead81_q <= (data == 8'h81);
      if (byte_idx == CNT_W'(13)) tagged_q <= lead81_q && (data == 8'h00);
      if (byte_idx == pos) begin
        type_byte <= data;
        seen_q    <= 1'b1;
      end
    end
  end

  // A stale flag from the previous frame is masked on byte 0 of a new one.
  assign type_valid = seen_q && (byte_idx != '0);
endmodule

// File: rtl/ptp_evt_classifier.sv
module ptp_evt_classifier
  import ptp_cls_pkg::*;
#(
  parameter int unsigned NUM_PORTS   = 3,
  parameter int unsigned PORT_SEL    = 0,
  parameter int unsigned PAYLOAD_OFS = 42,
  parameter int unsigned VLAN_BYTES  = 4,
  parameter int unsigned MSG_OFS     = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rx_valid,
  input  logic                        rx_sof,
  input  logic                        rx_eof,
  input  logic [7:0]                  rx_data,
  input  logic                        rx_fcs_ok,
  input  logic [15:0]                 cfg_user_hi,
  input  logic [31:0]                 cfg_user_lo,
  input  logic [NUM_ADDR*NUM_PORTS-1:0] cfg_addr_en,
  output logic                        ptp_hit,
  output logic                        ptp_is_delay_req,
  output logic [IDX_W-1:0]            ptp_addr_idx
);
  localparam int unsigned UNTAG_POS = PAYLOAD_OFS + MSG_OFS;
  localparam int unsigned TAG_POS   = UNTAG_POS + VLAN_BYTES;
  localparam int unsigned CNT_W     = $clog2(TAG_POS + 2) + 1;

  logic [CNT_W-1:0]    cnt_q;
  logic [CNT_W-1:0]    idx_now;
  logic [NUM_ADDR-1:0] port_en;
  logic [NUM_ADDR-1:0] hit_vec;
  logic                type_valid;
  logic [7:0]          type_byte;
  logic [IDX_W-1:0]    first_idx;
  logic                classify;

  assign idx_now = rx_sof ? '0 : cnt_q;
  assign port_en = cfg_addr_en[PORT_SEL*NUM_ADDR +: NUM_ADDR];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (rx_valid && idx_now != '1) begin
      cnt_q <= idx_now + 1'b1;
    end else if (rx_valid) begin
      cnt_q <= idx_now;
    end
  end

  ptp_da_match #(.CNT_W(CNT_W)) da_i (
    .clk(clk), .rst(rst), .beat(rx_valid), .byte_idx(idx_now), .data(rx_data),
    .user_da({cfg_user_hi, cfg_user_lo}), .en(port_en), .hit_vec(hit_vec)
  );

  ptp_type_pick #(.CNT_W(CNT_W), .UNTAG_POS(UNTAG_POS), .TAG_POS(TAG_POS)) tp_i (
    .clk(clk), .rst(rst), .beat(rx_valid), .byte_idx(idx_now), .data(rx_data),
    .type_valid(type_valid), .type_byte(type_byte)
  );

  // Lowest-numbered matching address wins.
  always_comb begin
    first_idx = '0;
    for (int a = NUM_ADDR - 1; a >= 0; a--) begin
      if (hit_vec[a]) first_idx = IDX_W'(a);
    end
  end

  assign classify = rx_valid && rx_eof && rx_fcs_ok && (|hit_vec) && type_valid &&
                    (type_byte == MSG_SYNC || type_byte == MSG_DELAY);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptp_hit          <= 1'b0;
      ptp_is_delay_req <= 1'b0;
      ptp_addr_idx     <= '0;
    end else begin
      ptp_hit          <= classify;
      ptp_is_delay_req <= classify && (type_byte == MSG_DELAY);
      ptp_addr_idx     <= classify ? first_idx : '0;
    end
  end
endmodule

// File: rtl/ptp_evt_classifier_chk.sv
module ptp_evt_classifier_chk
  import ptp_cls_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 3,
  parameter int unsigned PORT_SEL  = 0
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          rx_valid,
  input logic                          rx_eof,
  input logic                          rx_fcs_ok,
  input logic [NUM_ADDR*NUM_PORTS-1:0] cfg_addr_en,
  input logic                          ptp_hit,
  input logic                          ptp_is_delay_req,
  input logic [IDX_W-1:0]              ptp_addr_idx
);
  logic [NUM_ADDR-1:0] en_d;
  always_ff @(posedge clk) en_d <= cfg_addr_en[PORT_SEL*NUM_ADDR +: NUM_ADDR];

  AST_HIT_NEEDS_FCS: assert property (@(posedge clk) disable iff (rst)
    ptp_hit |-> $past(rx_fcs_ok)); // R1
  AST_HIT_AFTER_EOF: assert property (@(posedge clk) disable iff (rst)
    ptp_hit |-> $past(rx_valid && rx_eof)); // R10
  AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ptp_hit |=> !ptp_hit); // R10
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !ptp_hit |-> (ptp_addr_idx == '0 && !ptp_is_delay_req)); // R10
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    ptp_hit |-> (ptp_addr_idx < IDX_W'(NUM_ADDR))); // R2
  AST_IDX_ENABLED: assert property (@(posedge clk) disable iff (rst)
    (ptp_hit && ptp_addr_idx < IDX_W'(NUM_ADDR)) |-> en_d[ptp_addr_idx]); // R4
endmodule

bind ptp_evt_classifier ptp_evt_classifier_chk #(.NUM_PORTS(NUM_PORTS), .PORT_SEL(PORT_SEL)) chk_i (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_eof(rx_eof), .rx_fcs_ok(rx_fcs_ok),
  .cfg_addr_en(cfg_addr_en), .ptp_hit(ptp_hit), .ptp_is_delay_req(ptp_is_delay_req),
  .ptp_addr_idx(ptp_addr_idx)
);

// File: tb/ptp_evt_classifier_tb_top.sv
module ptp_evt_classifier_tb_top;
  localparam int NP = 3;
  localparam int PS = 1;
  typedef logic [7:0] bq_t[$];

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_fcs_ok = 1'b0;
  logic [7:0] rx_data = '0;
  logic [15:0] cfg_user_hi = '0;
  logic [31:0] cfg_user_lo = '0;
  logic [5*NP-1:0] cfg_addr_en = '1;
  logic ptp_hit, ptp_is_delay_req;
  logic [2:0] ptp_addr_idx;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ptp_evt_classifier #(.NUM_PORTS(NP), .PORT_SEL(PS)) dut_i (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_data(rx_data), .rx_fcs_ok(rx_fcs_ok), .cfg_user_hi(cfg_user_hi),
    .cfg_user_lo(cfg_user_lo), .cfg_addr_en(cfg_addr_en), .ptp_hit(ptp_hit),
    .ptp_is_delay_req(ptp_is_delay_req), .ptp_addr_idx(ptp_addr_idx)
  );

  // Behavioural reference model: collects the frame, evaluates at the end beat.
  bq_t m_frame;
  logic m_hit = 0, m_dly = 0;
  logic [2:0] m_idx = '0;

  function automatic logic [47:0] addr_of(int a);
    if (a < 4) return 48'h01005e000181 + 48'(a);
    return {cfg_user_hi, cfg_user_lo};
  endfunction

  always @(posedge clk) begin
    logic h, d;
    logic [2:0] ix;
    h = 0; d = 0; ix = '0;
    if (rst) begin
      m_frame = {};
    end else if (rx_valid) begin
      if (rx_sof) m_frame = {};
      m_frame.push_back(rx_data);
      if (rx_eof && rx_fcs_ok && m_frame.size() > 6) begin
        logic [47:0] da;
        int pos;
        int found;
        da = {m_frame[0], m_frame[1], m_frame[2], m_frame[3], m_frame[4], m_frame[5]};
        pos = (m_frame.size() > 13 && m_frame[12] == 8'h81 && m_frame[13] == 8'h00) ? 78 : 74;
        found = -1;
        for (int a = 4; a >= 0; a--)
          if (cfg_addr_en[PS*5 + a] && da == addr_of(a)) found = a;
        if (found >= 0 && m_frame.size() - 1 > pos && m_frame[pos] <= 8'h01) begin
          h = 1; d = m_frame[pos][0]; ix = 3'(found);
        end
      end
    end
    m_hit <= h; m_dly <= d; m_idx <= ix;
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      n_checks++;
      if ({ptp_hit, ptp_is_delay_req, ptp_addr_idx} != {m_hit, m_dly, m_idx}) begin
        n_fail++;
        $display("FAIL R10 per-cycle model: got hit=%0b dly=%0b idx=%0d exp hit=%0b dly=%0b idx=%0d",
                 ptp_hit, ptp_is_delay_req, ptp_addr_idx, m_hit, m_dly, m_idx);
      end
    end
  end

  function automatic bq_t mk(logic [47:0] da, bit tag, logic [15:0] etype, int len,
                             int tpos, logic [7:0] tval);
    bq_t q;
    for (int i = 0; i < len; i++) q.push_back(8'(i * 7 + 3));
    for (int i = 0; i < 6; i++) q[i] = da[8*(5-i) +: 8];
    if (tag) begin q[12] = 8'h81; q[13] = 8'h00; q[16] = etype[15:8]; q[17] = etype[7:0]; end
    else begin q[12] = etype[15:8]; q[13] = etype[7:0]; end
    if (tpos < len) q[tpos] = tval;
    return q;
  endfunction

  task automatic send(bq_t q, bit fcs);
    for (int i = 0; i < q.size(); i++) begin
      @(negedge clk);
      rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == q.size() - 1);
      rx_data = q[i]; rx_fcs_ok = fcs;
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_fcs_ok = 0;
  endtask

  task automatic expect_out(string tagname, bit h, bit d, int ix);
    n_checks++;
    if (ptp_hit !== h || ptp_is_delay_req !== d || ptp_addr_idx !== 3'(ix)) begin
      n_fail++;
      $display("FAIL %s: got hit=%0b dly=%0b idx=%0d exp hit=%0b dly=%0b idx=%0d",
               tagname, ptp_hit, ptp_is_delay_req, ptp_addr_idx, h, d, ix);
    end
  endtask

  task automatic run(string tagname, bq_t q, bit fcs, bit h, bit d, int ix);
    send(q, fcs);
    expect_out(tagname, h, d, ix);
    @(negedge clk);
    expect_out({tagname, " pulse end R10"}, 0, 0, 0);
    repeat (3) @(negedge clk);
  endtask

  localparam logic [47:0] P0 = 48'h01005e000181;
  localparam logic [47:0] UA = 48'h021122334455;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    expect_out("R10 reset", 0, 0, 0);
    cfg_user_hi = UA[47:32]; cfg_user_lo = UA[31:0];
    run("R2 R6 primary sync", mk(P0, 0, 16'h0800, 90, 74, 8'h00), 1, 1, 0, 0);
    run("R2 alt1 delay", mk(P0 + 1, 0, 16'h0800, 90, 74, 8'h01), 1, 1, 1, 1);
    run("R2 alt2", mk(P0 + 2, 0, 16'h0800, 90, 74, 8'h00), 1, 1, 0, 2);
    run("R7 alt3 tagged", mk(P0 + 3, 1, 16'h0800, 95, 78, 8'h01), 1, 1, 1, 3);
    run("R3 user addr", mk(UA, 0, 16'h0800, 90, 74, 8'h01), 1, 1, 1, 4);
    run("R1 bad fcs", mk(P0, 0, 16'h0800, 90, 74, 8'h00), 0, 0, 0, 0);
    run("R8 other type", mk(P0, 0, 16'h0800, 90, 74, 8'h02), 1, 0, 0, 0);
    run("R9 ends on type byte", mk(P0, 0, 16'h0800, 75, 74, 8'h00), 1, 0, 0, 0);
    run("R9 one past type byte", mk(P0, 0, 16'h0800, 76, 74, 8'h00), 1, 1, 0, 0);
    run("R9 tagged ends on type byte", mk(P0, 1, 16'h0800, 79, 78, 8'h00), 1, 0, 0, 0);
    begin
      bq_t q;
      q = mk(P0, 1, 16'h0800, 95, 78, 8'h07);
      q[74] = 8'h00;
      run("R7 tagged ignores byte 74", q, 1, 0, 0, 0);
    end
    run("R11 odd ethertype", mk(P0 + 1, 0, 16'h1234, 90, 74, 8'h00), 1, 1, 0, 1);
    run("R2 unknown address", mk(P0 + 5, 0, 16'h0800, 90, 74, 8'h00), 1, 0, 0, 0);
    cfg_addr_en = '1;
    cfg_addr_en[PS*5 + 0] = 0;
    run("R4 primary disabled here", mk(P0, 0, 16'h0800, 90, 74, 8'h00), 1, 0, 0, 0);
    run("R4 alt1 still on", mk(P0 + 1, 0, 16'h0800, 90, 74, 8'h01), 1, 1, 1, 1);
    cfg_user_hi = P0[47:32]; cfg_user_lo = P0[31:0];
    run("R5 user same as primary, primary off", mk(P0, 0, 16'h0800, 90, 74, 8'h00), 1, 1, 0, 4);
    cfg_addr_en = '1;
    run("R5 lowest index wins", mk(P0, 0, 16'h0800, 90, 74, 8'h01), 1, 1, 1, 0);
    begin
      bq_t part;
      part = mk(P0 + 2, 0, 16'h0800, 20, 74, 8'h00);
      for (int i = 0; i < part.size(); i++) begin
        @(negedge clk);
        rx_valid = 1; rx_sof = (i == 0); rx_eof = 0; rx_data = part[i]; rx_fcs_ok = 1;
      end
      run("R12 restart on sof", mk(P0 + 3, 0, 16'h0800, 88, 74, 8'h00), 1, 1, 0, 3);
    end
    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule